// File: doc/BRIEF.md
# Condition-Code ALU with Jump Predicate Unit

This block is the integer execute stage of a small processor core. Each cycle it may accept one operation on two 32-bit operands. It produces a registered result together with a one-cycle write-back strobe, and it updates a four-bit condition-code register. The four flags are zero, sign, unsigned carry/borrow and signed overflow.

A condition select picks one of ten jump predicates, or an always-taken or never-taken code. The predicate is evaluated combinationally from the stored flags and drives a branch-taken bit. A fetch unit can therefore use the outcome of the last flag-writing operation without waiting.

The compare and test operations only update the flags. They never raise the write-back strobe, so they can steer a later jump without disturbing a destination register.

Top module: `flag_alu`

## Requirements
- R1: While rst_n is low, result, result_wb, flags and the stored condition codes are all zero.
- R2: Operation code 0 (add) and code 1 (sub) are handled as follows. Add writes a+b, and CF is the carry out of bit 31. Sub writes a-b, and CF is the borrow, set when a < b unsigned. In both cases OF is two's-complement overflow, ZF is set when the 32-bit result is zero, and SF is bit 31 of the result. The flags output places CF at bit 0, ZF at bit 1, SF at bit 2 and OF at bit 3.
- R3: The logic operations are code 2 (and), code 3 (or) and code 4 (xor). Each writes its bitwise result, sets ZF and SF from that result, and clears CF and OF.
- R4: Code 6 (shift-left) writes a shifted left by b[4:0]. CF takes the last bit shifted out, and is 0 for a shift by zero. OF is cleared.
- R5: Code 5 (neg) writes 0-a. CF is set when a is nonzero. OF is set only when a is 32'h80000000.
- R6: Code 7 (compare) sets all four flags exactly as sub would. It raises no write-back strobe and leaves result unchanged.
- R7: Code 8 (test) sets ZF and SF from a&b and clears CF and OF. It raises no write-back strobe and leaves result unchanged.
- R8: result and result_wb reflect an accepted operation on the clock edge after issue is sampled high, and result_wb stays high for that one cycle only. With issue low, or with an unused code (9 to 15), the flags and result are held and result_wb is 0.
- R9: The predicate codes on cond_sel are:
  - 0: always taken.
  - 1: ZF.
  - 2: !ZF.
  - 3: SF.
  - 4: !SF.
  - 5: !(SF^OF)&!ZF.
  - 6: !(SF^OF).
  - 7: SF^OF.
  - 8: (SF^OF)|ZF.
  - 9: !CF&!ZF.
  - 10: CF.
- R10: taken is computed from the stored flags. When a flag-writing operation is issued, taken shows the old flags until that edge and the new flags after it. Codes 11 to 15 are never taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | Operation accepted this cycle |
| op_sel | input | 4 | Operation code |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand / shift amount |
| cond_sel | input | 4 | Jump predicate select |
| result | output | 32 | Registered result |
| result_wb | output | 1 | One-cycle write-back strobe |
| flags | output | 4 | Stored condition codes {OF,SF,ZF,CF} |
| taken | output | 1 | Selected predicate is true |

## Verification
A flag update and a predicate evaluation can fall in the same cycle. The bench provokes this by issuing a compare while cond_sel already selects a predicate whose value the compare will flip. The bench reads taken just before the edge and expects the predicate of the previous flags. It reads taken again just after the edge and expects the predicate of the flags that the compare produced.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_NEG  = 4'd5,
        OP_SHL  = 4'd6,
        OP_CMP  = 4'd7,
        OP_TEST = 4'd8
    } op_e;

    typedef enum logic [3:0] {
        CC_ALWAYS = 4'd0,
        CC_EQ     = 4'd1,
        CC_NE     = 4'd2,
        CC_NEG    = 4'd3,
        CC_NNEG   = 4'd4,
        CC_GT     = 4'd5,
        CC_GE     = 4'd6,
        CC_LT     = 4'd7,
        CC_LE     = 4'd8,
        CC_ABOVE  = 4'd9,
        CC_BELOW  = 4'd10
    } cond_e;

    // packed order gives bit3=of, bit2=sf, bit1=zf, bit0=cf
    typedef struct packed {
        logic of;
        logic sf;
        logic zf;
        logic cf;
    } flags_t;

endpackage

// File: rtl/alu_datapath.sv
module alu_datapath
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output flags_t       fl,
    output logic         wr_res,
    output logic         wr_flags
);
    localparam int SHW = $clog2(W);
    localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

    logic [W:0]     sum;
    logic [W:0]     diff;
    logic [W:0]     shx;
    logic [SHW-1:0] sh;
    logic [W-1:0]   val;

    always_comb begin
        sum  = {1'b0, a} + {1'b0, b};
        diff = {1'b0, a} - {1'b0, b};
        sh   = b[SHW-1:0];
        shx  = {1'b0, a} << sh;

        val      = '0;
        fl       = '0;
        wr_res   = 1'b1;
        wr_flags = 1'b1;
        unique case (op)
            OP_ADD: begin
                val   = sum[W-1:0];
                fl.cf = sum[W];
                fl.of = (a[W-1] == b[W-1]) && (val[W-1] != a[W-1]);
            end
            OP_SUB, OP_CMP: begin
                val    = diff[W-1:0];
                fl.cf  = diff[W];
                fl.of  = (a[W-1] != b[W-1]) && (val[W-1] != a[W-1]);
                wr_res = (op == OP_SUB);
            end
            OP_AND, OP_TEST: begin
                val    = a & b;
                wr_res = (op == OP_AND);
            end
            OP_OR:  val = a | b;
            OP_XOR: val = a ^ b;
            OP_NEG: begin
                val   = '0 - a;
                fl.cf = |a;
                fl.of = (a == MIN_NEG);
            end
            OP_SHL: begin
                val   = shx[W-1:0];
                fl.cf = shx[W];
            end
            default: begin
                wr_res   = 1'b0;
                wr_flags = 1'b0;
            end
        endcase
        fl.zf = (val == '0);
        fl.sf = val[W-1];
        res   = val;
    end

endmodule

// File: rtl/cond_decode.sv
module cond_decode
    import alu_pkg::*;
(
    input  logic [3:0] sel,
    input  flags_t     fl,
    output logic       taken
);
    logic lt;

    always_comb begin
        lt = fl.sf ^ fl.of;
        unique case (sel)
            CC_ALWAYS: taken = 1'b1;
            CC_EQ:     taken = fl.zf;
            CC_NE:     taken = !fl.zf;
            CC_NEG:    taken = fl.sf;
            CC_NNEG:   taken = !fl.sf;
            CC_GT:     taken = !lt && !fl.zf;
            CC_GE:     taken = !lt;
            CC_LT:     taken = lt;
            CC_LE:     taken = lt || fl.zf;
            CC_ABOVE:  taken = !fl.cf && !fl.zf;
            CC_BELOW:  taken = fl.cf;
            default:   taken = 1'b0;
        endcase
    end

endmodule

// File: rtl/flag_alu.sv
module flag_alu
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         issue,
    input  logic [3:0]   op_sel,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic [3:0]   cond_sel,
    output logic [W-1:0] result,
    output logic         result_wb,
    output logic [3:0]   flags,
    output logic         taken
);
    typedef struct packed {
        logic [W-1:0] res;
        logic         wb;
        flags_t       fl;
    } state_t;

    state_t       st_d, st_q;
    logic [W-1:0] dp_res;
    flags_t       dp_fl;
    logic         dp_wr_res;
    logic         dp_wr_fl;

    alu_datapath #(.W(W)) u_dp (
        .op       (op_sel),
        .a        (opnd_a),
        .b        (opnd_b),
        .res      (dp_res),
        .fl       (dp_fl),
        .wr_res   (dp_wr_res),
        .wr_flags (dp_wr_fl)
    );

    always_comb begin
        st_d    = st_q;
        st_d.wb = issue && dp_wr_res;
        if (issue && dp_wr_res) st_d.res = dp_res;
        if (issue && dp_wr_fl)  st_d.fl  = dp_fl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    cond_decode u_cc (
        .sel   (cond_sel),
        .fl    (st_q.fl),
        .taken (taken)
    );

    assign result    = st_q.res;
    assign result_wb = st_q.wb;
    assign flags     = st_q.fl;

endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         issue,
    input logic [3:0]   op_sel,
    input logic [3:0]   cond_sel,
    input logic [W-1:0] result,
    input logic         result_wb,
    input logic [3:0]   flags,
    input logic         taken
);
    AST_WB_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        result_wb |-> (flags[1] == (result == '0))); // R2
    AST_WB_SIGN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        result_wb |-> (flags[2] == result[W-1])); // R3
    AST_CMP_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && (op_sel == 4'd7)) |=> (!result_wb && $stable(result))); // R6
    AST_TEST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && (op_sel == 4'd8)) |=> (!flags[0] && !flags[3] && !result_wb)); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> (!result_wb && $stable(flags) && $stable(result))); // R8
    AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_sel == 4'd0) |-> taken); // R9
    AST_BELOW_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_sel == 4'd10) |-> (taken == flags[0])); // R9
    AST_UNUSED_COND: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_sel > 4'd10) |-> !taken); // R10
endmodule

bind flag_alu flag_alu_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue     (issue),
    .op_sel    (op_sel),
    .cond_sel  (cond_sel),
    .result    (result),
    .result_wb (result_wb),
    .flags     (flags),
    .taken     (taken)
);

// File: tb/sim_flag_alu.sv
`timescale 1ns/1ps
module sim_flag_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [3:0]  op_sel = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [3:0]  cond_sel = '0;
    logic [31:0] result;
    logic        result_wb;
    logic [3:0]  flags;
    logic        taken;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [31:0] res;
        logic        wb;
        logic [3:0]  fl;
        string       req;
    } exp_t;
    exp_t sb[$];

    logic [31:0] m_res = '0;
    logic [3:0]  m_fl  = '0;

    always #2.5 clk = ~clk;

    flag_alu u0 (
        .clk(clk), .rst_n(rst_n), .issue(issue), .op_sel(op_sel),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .cond_sel(cond_sel),
        .result(result), .result_wb(result_wb), .flags(flags), .taken(taken)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic pred(logic [3:0] c, logic [3:0] f);
        logic cf, zf, sf, of;
        {of, sf, zf, cf} = f;
        case (c)
            4'd0:    return 1'b1;
            4'd1:    return zf;
            4'd2:    return !zf;
            4'd3:    return sf;
            4'd4:    return !sf;
            4'd5:    return (sf == of) && !zf;
            4'd6:    return sf == of;
            4'd7:    return sf != of;
            4'd8:    return (sf != of) || zf;
            4'd9:    return !cf && !zf;
            4'd10:   return cf;
            default: return 1'b0;
        endcase
    endfunction

    // reference model written from the requirements; updates m_res / m_fl
    task automatic model(logic [3:0] op, logic [31:0] a, logic [31:0] b, output logic wb);
        logic [31:0] r;
        logic        cf, of;
        int          k;
        cf = 1'b0; of = 1'b0; r = '0; wb = 1'b0;
        case (op)
            4'd0: begin
                r  = a + b;
                cf = (64'(a) + 64'(b)) > 64'hFFFF_FFFF;
                of = ($signed(a) >= 0) == ($signed(b) >= 0) && (($signed(r) >= 0) != ($signed(a) >= 0));
            end
            4'd1, 4'd7: begin
                r  = a - b;
                cf = a < b;
                of = (($signed(a) >= 0) != ($signed(b) >= 0)) && (($signed(r) >= 0) != ($signed(a) >= 0));
            end
            4'd2, 4'd8: r = a & b;
            4'd3: r = a | b;
            4'd4: r = a ^ b;
            4'd5: begin r = ~a + 32'd1; cf = (a != 0); of = (a == 32'h8000_0000); end
            4'd6: begin
                k  = int'(b[4:0]);
                r  = a << k;
                cf = (k == 0) ? 1'b0 : a[32 - k];
            end
            default: ;
        endcase
        if (op <= 4'd8) m_fl = {of, r[31], (r == 0), cf};
        if (op <= 4'd6) begin wb = 1'b1; m_res = r; end
    endtask

    task automatic drive(string req, logic [3:0] op, logic [31:0] a, logic [31:0] b, logic act);
        exp_t e;
        logic wb;
        @(negedge clk);
        issue = act; op_sel = op; opnd_a = a; opnd_b = b;
        if (act) model(op, a, b, wb); else wb = 1'b0;
        e.res = m_res; e.wb = wb; e.fl = m_fl; e.req = req;
        sb.push_back(e);
    endtask

    // monitor: one expectation per edge at which the driver staged stimulus
    always @(posedge clk) begin
        exp_t e;
        #1;
        if (sb.size() > 0) begin
            e = sb.pop_front();
            check(e.req, result, e.res);
            check(e.req, 32'(result_wb), 32'(e.wb));
            check(e.req, 32'(flags), 32'(e.fl));
        end
    end

    task automatic run(string req, logic [3:0] op, logic [31:0] a, logic [31:0] b);
        drive(req, op, a, b, 1'b1);
        drive(req, op, a, b, 1'b0);
    endtask

    task automatic sweep_conds();
        for (int c = 0; c < 16; c++) begin
            @(negedge clk);
            cond_sel = 4'(c);
            #1;
            check((c > 10) ? "R10" : "R9", 32'(taken), 32'(pred(4'(c), m_fl)));
        end
    endtask

    task automatic overlap(logic [3:0] c, logic [3:0] op, logic [31:0] a, logic [31:0] b);
        logic old_p;
        old_p = pred(c, m_fl);
        cond_sel = c;
        drive("R10", op, a, b, 1'b1);
        #1;
        check("R10", 32'(taken), 32'(old_p));  // R10 old flags before edge
        @(posedge clk);
        #1;
        check("R10", 32'(taken), 32'(pred(c, m_fl)));  // R10 new flags after edge
        drive("R10", op, a, b, 1'b0);
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1", result, 32'd0);
        check("R1", 32'(result_wb), 32'd0);
        check("R1", 32'(flags), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        run("R2", 4'd0, 32'd5, 32'd7);
        run("R2", 4'd0, 32'hFFFF_FFFF, 32'd1);
        run("R2", 4'd0, 32'h7FFF_FFFF, 32'd1);
        run("R2", 4'd1, 32'd5, 32'd7);
        run("R2", 4'd1, 32'd7, 32'd7);
        run("R2", 4'd1, 32'h8000_0000, 32'd1);
        run("R3", 4'd2, 32'hF0F0_1234, 32'h0FF0_FFFF);
        run("R3", 4'd3, 32'h8000_0000, 32'd3);
        run("R3", 4'd4, 32'hA5A5_A5A5, 32'hA5A5_A5A5);
        run("R4", 4'd6, 32'h8000_0001, 32'd1);
        run("R4", 4'd6, 32'h1234_5678, 32'd0);
        run("R4", 4'd6, 32'h4000_0000, 32'd2);
        run("R4", 4'd6, 32'h0000_0003, 32'd31);
        run("R5", 4'd5, 32'd0, 32'd0);
        run("R5", 4'd5, 32'd5, 32'd0);
        run("R5", 4'd5, 32'h8000_0000, 32'd0);
        run("R6", 4'd7, 32'd5, 32'd7);
        sweep_conds();
        run("R6", 4'd7, 32'd7, 32'd7);
        sweep_conds();
        run("R6", 4'd7, 32'h8000_0000, 32'd1);
        sweep_conds();
        run("R6", 4'd7, 32'd9, 32'd3);
        sweep_conds();
        run("R7", 4'd8, 32'h0000_00F0, 32'h0000_000F);
        run("R7", 4'd8, 32'h8000_0000, 32'hFFFF_FFFF);
        run("R8", 4'd9, 32'd1, 32'd2);
        run("R8", 4'd15, 32'd0, 32'd0);
        drive("R8", 4'd0, 32'd1, 32'd1, 1'b0);
        run("R8", 4'd0, 32'd1, 32'd1);
        run("R8", 4'd0, 32'd2, 32'd2);
        overlap(4'd1, 4'd7, 32'd4, 32'd4);
        overlap(4'd1, 4'd7, 32'd4, 32'd5);
        overlap(4'd10, 4'd7, 32'd1, 32'd2);
        overlap(4'd5, 4'd7, 32'd9, 32'd2);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule